// File: doc/BRIEF.md
# SDRAM Auto-Precharge Burst Write Sequencer

This block turns one write request into the complete pin sequence that an SDR SDRAM needs for a four-beat burst write to a single bank. The request carries a bank, a row, a column and four data words. The block first opens the row. After the row-to-column delay it issues the write command with the auto-precharge address bit set. It then streams the four words on consecutive clocks, and after that it keeps every bank closed to new row activations until the device has finished recovering and precharging by itself.

Every delay is held as a whole number of clocks. Each count is derived at elaboration from a nanosecond figure (given in picoseconds) and the clock period, rounded up. The shortest legal spacing between two row activations is the largest of three paths: burst, write recovery and precharge; row-active time plus precharge; and the row cycle time. A request is accepted only while the block is idle. The block becomes idle again in the last clock before that spacing runs out, so a request held waiting is turned into a new activation at the earliest legal clock. Clock enable is tied high.

Top module: `sdram_apwr_seq`

## Requirements
- R1: While reset is low and right after it is released, `req_ready_o` is 1, the command pins show NOP, `sd_dq_oe_o` is 0, every `sd_dqm_o` bit is 1 and `sd_cke_o` is 1. The command pins {cs_n,ras_n,cas_n,we_n} use these codes: NOP = 0111, ACTIVE = 0011, WRITE = 0100.
- R2: A request is taken at a rising edge where `req_valid_i` and `req_ready_o` are both 1. In the next clock the pins show ACTIVE, with the request bank on `sd_ba_o` and the row zero-extended on `sd_addr_o`.
- R3: WRITE appears exactly RCD clocks after ACTIVE. RCD = ceil(TRCD_PS/TCK_PS), with a minimum of 1 (3 with the default parameters).
- R4: During WRITE, `sd_ba_o` carries the accepted bank and `sd_addr_o` carries the column on bits [COL_W-1:0]. Bit AP_BIT (10) is 1 to request auto precharge. All other address bits are 0.
- R5: Data word k (k = 0..3) is `req_data_i[32k+31:32k]` and is driven on `sd_dq_o` in clock WRITE+k. `sd_dq_oe_o` is 1 in exactly those four clocks.
- R6: `sd_dqm_o` is all 0 in every data clock and all 1 in every other clock.
- R7: The clock distance between two ACTIVE commands is never below GAP. GAP = max(RCD+3+WR+RP, RAS+RP, RC), with WR = 1+ceil(TWR_EXTRA_PS/TCK_PS) and the other counts taken as ceil(t/TCK_PS) (GAP = 11 with the defaults). `req_ready_o` is 0 from the clock of an ACTIVE until GAP-1 clocks after it.
- R8: While the block is busy, `req_valid_i` and changes on the request fields are ignored and produce no pin activity. Changing the request fields after acceptance does not alter the burst in progress.
- R9: In every clock that is not ACTIVE or WRITE, the command pins show NOP and `sd_ba_o` and `sd_addr_o` are 0. `sd_cke_o` is always 1.
- R10: If a request is held valid while the block is busy, its ACTIVE appears exactly GAP clocks after the previous ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request will be taken |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Row to open |
| req_col_i | input | COL_W | Starting column |
| req_data_i | input | BURST_LEN*DQ_W | Four write words, word 0 in the low bits |
| sd_cke_o | output | 1 | Clock enable, always high |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ADDR_W | Row or column address, bit 10 selects auto precharge |
| sd_dq_o | output | DQ_W | Write data |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dqm_o | output | DQ_W/8 | Byte masks, high masks the byte |

## Verification
The hardest case to reach from the ports is a request that is already waiting when the block is deep in its recovery window. That request must become an ACTIVE exactly at the first legal clock, no earlier, and it must not pick up field values that changed while it waited. The stimulus keeps `req_valid_i` high across three requests in a row and changes the fields while the block is busy. It also sends one request in the middle of the window and one well after it has closed. For each request the bench derives the expected ACTIVE clock on its own, from the previous ACTIVE and the clock at which the request was raised.

// File: rtl/sdram_apwr_pkg.sv
package sdram_apwr_pkg;

    // command pin code {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP   = 4'b0111,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100
    } sd_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } ph_state_e;

    // clocks needed to cover t_ps, rounded up
    function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdram_apwr_phase.sv
module sdram_apwr_phase
    import sdram_apwr_pkg::*;
#(
    parameter int unsigned RCD_CYC   = 3,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned GAP_CYC   = 11,
    parameter int unsigned PH_W      = 4,
    parameter int unsigned IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             idle_o,
    output logic             act_nxt_o,
    output logic             wr_nxt_o,
    output logic             beat_nxt_o,
    output logic [IDX_W-1:0] beat_idx_nxt_o
);

    localparam logic [PH_W-1:0] RCD_PH  = PH_W'(RCD_CYC);
    localparam logic [PH_W-1:0] BEND_PH = PH_W'(RCD_CYC + BURST_LEN);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(GAP_CYC - 2);

    typedef struct packed {
        ph_state_e       st;
        logic [PH_W-1:0] ph;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic run_d;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.st = PH_RUN;
                    ctl_d.ph = '0;
                end
            end
            PH_RUN: begin
                if (ctl_q.ph == LAST_PH) begin
                    ctl_d.st = PH_IDLE;
                    ctl_d.ph = '0;
                end else begin
                    ctl_d.ph = ctl_q.ph + 1'b1;
                end
            end
            default: ctl_d = '{st: PH_IDLE, ph: '0};
        endcase

        run_d          = (ctl_d.st == PH_RUN);
        act_nxt_o      = run_d && (ctl_d.ph == '0);
        wr_nxt_o       = run_d && (ctl_d.ph == RCD_PH);
        beat_nxt_o     = run_d && (ctl_d.ph >= RCD_PH) && (ctl_d.ph < BEND_PH);
        beat_idx_nxt_o = IDX_W'(ctl_d.ph - RCD_PH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: PH_IDLE, ph: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idle_o = (ctl_q.st == PH_IDLE);

endmodule

// File: rtl/sdram_apwr_burst.sv
module sdram_apwr_burst #(
    parameter int unsigned DQ_W      = 32,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned COL_W     = 8,
    parameter int unsigned IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [BA_W-1:0]            bank_i,
    input  logic [COL_W-1:0]           col_i,
    input  logic [BURST_LEN*DQ_W-1:0]  data_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [BA_W-1:0]            bank_o,
    output logic [COL_W-1:0]           col_o,
    output logic [DQ_W-1:0]            word_o
);

    typedef struct packed {
        logic [BA_W-1:0]           bank;
        logic [COL_W-1:0]          col;
        logic [BURST_LEN*DQ_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [DQ_W-1:0] words [BURST_LEN];

    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d.bank = bank_i;
            hold_d.col  = col_i;
            hold_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    for (genvar g = 0; g < BURST_LEN; g++) begin : g_word
        assign words[g] = hold_q.data[g*DQ_W +: DQ_W];
    end

    assign bank_o = hold_q.bank;
    assign col_o  = hold_q.col;
    assign word_o = words[idx_i];

endmodule

// File: rtl/sdram_apwr_pins.sv
module sdram_apwr_pins
    import sdram_apwr_pkg::*;
#(
    parameter int unsigned DQ_W   = 32,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned AP_BIT = 10,
    parameter int unsigned DQM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              wr_i,
    input  logic              beat_i,
    input  logic [BA_W-1:0]   act_bank_i,
    input  logic [ROW_W-1:0]  act_row_i,
    input  logic [BA_W-1:0]   wr_bank_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic [DQ_W-1:0]   word_i,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe_o,
    output logic [DQM_W-1:0]  dqm_o
);

    typedef struct packed {
        logic [3:0]        cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   dq;
        logic              oe;
        logic [DQM_W-1:0]  dqm;
    } pin_t;

    localparam pin_t PIN_REST = '{cmd: CMD_NOP, ba: '0, addr: '0, dq: '0, oe: 1'b0, dqm: '1};

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d = PIN_REST;
        if (act_i) begin
            pin_d.cmd  = CMD_ACT;
            pin_d.ba   = act_bank_i;
            pin_d.addr = ADDR_W'(act_row_i);
        end else if (wr_i) begin
            pin_d.cmd                = CMD_WRITE;
            pin_d.ba                 = wr_bank_i;
            pin_d.addr[COL_W-1:0]    = wr_col_i;
            pin_d.addr[AP_BIT]       = 1'b1;
        end
        if (beat_i) begin
            pin_d.oe  = 1'b1;
            pin_d.dq  = word_i;
            pin_d.dqm = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= PIN_REST;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign cmd_o   = pin_q.cmd;
    assign ba_o    = pin_q.ba;
    assign addr_o  = pin_q.addr;
    assign dq_o    = pin_q.dq;
    assign dq_oe_o = pin_q.oe;
    assign dqm_o   = pin_q.dqm;

endmodule

// File: rtl/sdram_apwr_seq.sv
module sdram_apwr_seq
    import sdram_apwr_pkg::*;
#(
    parameter int unsigned TCK_PS       = 6000,
    parameter int unsigned TRCD_PS      = 18000,
    parameter int unsigned TWR_EXTRA_PS = 6000,
    parameter int unsigned TRP_PS       = 18000,
    parameter int unsigned TRC_PS       = 60000,
    parameter int unsigned TRAS_PS      = 42000,
    parameter int unsigned BURST_LEN    = 4,
    parameter int unsigned DQ_W         = 32,
    parameter int unsigned BA_W         = 2,
    parameter int unsigned ROW_W        = 12,
    parameter int unsigned COL_W        = 8,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned AP_BIT       = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    output logic                      req_ready_o,
    input  logic [BA_W-1:0]           req_bank_i,
    input  logic [ROW_W-1:0]          req_row_i,
    input  logic [COL_W-1:0]          req_col_i,
    input  logic [BURST_LEN*DQ_W-1:0] req_data_i,
    output logic                      sd_cke_o,
    output logic                      sd_cs_n_o,
    output logic                      sd_ras_n_o,
    output logic                      sd_cas_n_o,
    output logic                      sd_we_n_o,
    output logic [BA_W-1:0]           sd_ba_o,
    output logic [ADDR_W-1:0]         sd_addr_o,
    output logic [DQ_W-1:0]           sd_dq_o,
    output logic                      sd_dq_oe_o,
    output logic [DQ_W/8-1:0]         sd_dqm_o
);

    localparam int unsigned RCD_CYC = at_least_one(cyc_of(TRCD_PS, TCK_PS));
    localparam int unsigned WR_CYC  = 1 + cyc_of(TWR_EXTRA_PS, TCK_PS);
    localparam int unsigned RP_CYC  = at_least_one(cyc_of(TRP_PS, TCK_PS));
    localparam int unsigned RC_CYC  = cyc_of(TRC_PS, TCK_PS);
    localparam int unsigned RAS_CYC = cyc_of(TRAS_PS, TCK_PS);
    localparam int unsigned GAP_CYC = max3(RCD_CYC + BURST_LEN - 1 + WR_CYC + RP_CYC,
                                           RAS_CYC + RP_CYC, RC_CYC);
    localparam int unsigned PH_W    = $clog2(GAP_CYC + 1);
    localparam int unsigned IDX_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int unsigned DQM_W   = DQ_W / 8;

    logic             idle, start;
    logic             act_nxt, wr_nxt, beat_nxt;
    logic [IDX_W-1:0] beat_idx;
    logic [BA_W-1:0]  held_bank;
    logic [COL_W-1:0] held_col;
    logic [DQ_W-1:0]  beat_word;
    logic [3:0]       cmd;

    assign start       = req_valid_i & idle;
    assign req_ready_o = idle;
    assign sd_cke_o    = 1'b1;

    sdram_apwr_phase #(
        .RCD_CYC   (RCD_CYC),
        .BURST_LEN (BURST_LEN),
        .GAP_CYC   (GAP_CYC),
        .PH_W      (PH_W),
        .IDX_W     (IDX_W)
    ) u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .idle_o         (idle),
        .act_nxt_o      (act_nxt),
        .wr_nxt_o       (wr_nxt),
        .beat_nxt_o     (beat_nxt),
        .beat_idx_nxt_o (beat_idx)
    );

    sdram_apwr_burst #(
        .DQ_W      (DQ_W),
        .BURST_LEN (BURST_LEN),
        .BA_W      (BA_W),
        .COL_W     (COL_W),
        .IDX_W     (IDX_W)
    ) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start),
        .bank_i (req_bank_i),
        .col_i  (req_col_i),
        .data_i (req_data_i),
        .idx_i  (beat_idx),
        .bank_o (held_bank),
        .col_o  (held_col),
        .word_o (beat_word)
    );

    sdram_apwr_pins #(
        .DQ_W   (DQ_W),
        .BA_W   (BA_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT),
        .DQM_W  (DQM_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act_nxt),
        .wr_i       (wr_nxt),
        .beat_i     (beat_nxt),
        .act_bank_i (req_bank_i),
        .act_row_i  (req_row_i),
        .wr_bank_i  (held_bank),
        .wr_col_i   (held_col),
        .word_i     (beat_word),
        .cmd_o      (cmd),
        .ba_o       (sd_ba_o),
        .addr_o     (sd_addr_o),
        .dq_o       (sd_dq_o),
        .dq_oe_o    (sd_dq_oe_o),
        .dqm_o      (sd_dqm_o)
    );

    assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;

endmodule

// File: rtl/sdram_apwr_chk.sv
module sdram_apwr_chk #(
    parameter int unsigned RCD_CYC   = 3,
    parameter int unsigned GAP_CYC   = 11,
    parameter int unsigned BURST_LEN = 4,
    parameter int unsigned DQM_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid,
    input logic             ready,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             ap,
    input logic             oe,
    input logic [DQM_W-1:0] dqm
);

    localparam int unsigned CW = $clog2(GAP_CYC + 2);
    localparam int unsigned RW = $clog2(BURST_LEN + 2);
    localparam logic [CW-1:0] GAP_C  = CW'(GAP_CYC);
    localparam logic [CW-1:0] GAPM_C = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] RCD_C  = CW'(RCD_CYC);
    localparam logic [RW-1:0] BL_C   = RW'(BURST_LEN);

    logic [3:0]    cmd;
    logic          is_act, is_wr, is_nop;
    logic [CW-1:0] since_q;
    logic [RW-1:0] run_q;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_wr  = (cmd == 4'b0100);
    assign is_nop = (cmd == 4'b0111);

    // clocks since the last activation, saturating at GAP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= GAP_C;
        end else if (is_act) begin
            since_q <= CW'(1);
        end else if (since_q < GAP_C) begin
            since_q <= since_q + 1'b1;
        end
    end

    // length of the current run of data clocks so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (oe) begin
            if (run_q <= BL_C) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_cke_high_r1: assert property (@(posedge clk) disable iff (!rst_n) cke)
        else $error("clock enable dropped");

    p_accept_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> is_act)
        else $error("accepted request did not activate");

    p_write_after_rcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (since_q == RCD_C))
        else $error("write not at row-to-column delay");

    p_write_autopre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> ap)
        else $error("write without auto precharge bit");

    p_write_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (oe && run_q == '0))
        else $error("write does not start the data burst");

    p_beat_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (run_q < BL_C))
        else $error("data burst too long");

    p_beat_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !is_wr) |-> (run_q != '0))
        else $error("data beat without a write");

    p_dqm_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (dqm == '0))
        else $error("byte mask set during data");

    p_dqm_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (&dqm))
        else $error("byte mask cleared outside data");

    p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_q >= GAP_C))
        else $error("activation too early");

    p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (since_q >= GAPM_C))
        else $error("ready inside the recovery window");

    p_cmd_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_wr || is_nop))
        else $error("illegal command code");

endmodule

bind sdram_apwr_seq sdram_apwr_chk #(
    .RCD_CYC   (RCD_CYC),
    .GAP_CYC   (GAP_CYC),
    .BURST_LEN (BURST_LEN),
    .DQM_W     (DQM_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (req_valid_i),
    .ready (req_ready_o),
    .cke   (sd_cke_o),
    .cs_n  (sd_cs_n_o),
    .ras_n (sd_ras_n_o),
    .cas_n (sd_cas_n_o),
    .we_n  (sd_we_n_o),
    .ap    (sd_addr_o[AP_BIT]),
    .oe    (sd_dq_oe_o),
    .dqm   (sd_dqm_o)
);

// File: tb/sdram_apwr_seq_bench.sv
module sdram_apwr_seq_bench;

    // expected counts from the timing figures: 6 ns clock, 18/6/18/60/42 ns
    localparam int RCD = 3;                 // ceil(18/6)
    localparam int WR  = 2;                 // 1 + ceil(6/6)
    localparam int RP  = 3;                 // ceil(18/6)
    localparam int RC  = 10;                // ceil(60/6)
    localparam int RAS = 7;                 // ceil(42/6)
    localparam int GAP = 11;                // max(3+3+2+3, 7+3, 10)

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] ACT = 4'b0011;
    localparam logic [3:0] WRC = 4'b0100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_bank = '0;
    logic [11:0]  req_row = '0;
    logic [7:0]   req_col = '0;
    logic [127:0] req_data = '0;
    logic         cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]   ba;
    logic [11:0]  addr;
    logic [31:0]  dq;
    logic         dq_oe;
    logic [3:0]   dqm;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic        oe;
        logic [31:0] dq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    int   last_act = -1000;
    bit   done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_apwr_seq u_sdram_apwr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_bank_i  (req_bank),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .req_data_i  (req_data),
        .sd_cke_o    (cke),
        .sd_cs_n_o   (cs_n),
        .sd_ras_n_o  (ras_n),
        .sd_cas_n_o  (cas_n),
        .sd_we_n_o   (we_n),
        .sd_ba_o     (ba),
        .sd_addr_o   (addr),
        .sd_dq_o     (dq),
        .sd_dq_oe_o  (dq_oe),
        .sd_dqm_o    (dqm)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // driver: called at a falling edge, leaves at the falling edge after acceptance
    task automatic send(input logic [1:0] b, input logic [11:0] r,
                        input logic [7:0] c, input logic [127:0] d, input string ctag);
        int   drv;
        int   ea;
        exp_t e;
        drv = cyc;
        req_valid = 1'b1;
        req_bank  = b;
        req_row   = r;
        req_col   = c;
        req_data  = d;
        check("R7", "ready when request raised", 64'(req_ready),
              64'(drv >= last_act + GAP - 1));
        ea = (drv + 1 > last_act + GAP) ? drv + 1 : last_act + GAP;
        e = '{cyc: ea, cmd: ACT, ba: b, addr: r, oe: 1'b0, dq: '0, tag: ctag};
        exp_q.push_back(e);
        e = '{cyc: ea + RCD, cmd: WRC, ba: b, addr: 12'h400 | 12'(c), oe: 1'b1,
              dq: d[31:0], tag: "R4"};
        exp_q.push_back(e);
        for (int k = 1; k < 4; k++) begin
            e = '{cyc: ea + RCD + k, cmd: NOP, ba: '0, addr: '0, oe: 1'b1,
                  dq: d[k*32 +: 32], tag: "R5"};
            exp_q.push_back(e);
        end
        last_act = ea;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        req_bank  = ~req_bank;
        req_row   = ~req_row;
        req_col   = ~req_col;
        req_data  = ~req_data;
    endtask

    // monitor: compares pin activity against the expected queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] cmd;
            cmd = {cs_n, ras_n, cas_n, we_n};
            check("R9", "clock enable", 64'(cke), 64'd1);
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                exp_t m;
                m = exp_q.pop_front();
                check(m.tag, "expected activity missing at cycle", 64'(cyc), 64'(m.cyc));
            end
            if (cmd != NOP || dq_oe) begin
                if (exp_q.size() == 0) begin
                    check("R8", "unexpected pin activity cmd", 64'(cmd), 64'(NOP));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "cycle of activity", 64'(cyc), 64'(e.cyc));
                    check(e.tag, "command", 64'(cmd), 64'(e.cmd));
                    check(e.tag, "bank", 64'(ba), 64'(e.ba));
                    check(e.tag, "address", 64'(addr), 64'(e.addr));
                    check("R5", "output enable", 64'(dq_oe), 64'(e.oe));
                    if (e.oe) begin
                        check("R5", "data word", 64'(dq), 64'(e.dq));
                        check("R6", "byte mask in data clock", 64'(dqm), 64'd0);
                    end
                end
            end
            if (!dq_oe) begin
                check("R6", "byte mask outside data", 64'(dqm), 64'hF);
            end
            if (cmd == NOP) begin
                check("R9", "bank on NOP", 64'(ba), 64'd0);
                check("R9", "address on NOP", 64'(addr), 64'd0);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 4000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1", "ready in reset", 64'(req_ready), 64'd1);
        check("R1", "command in reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'(NOP));
        check("R1", "output enable in reset", 64'(dq_oe), 64'd0);
        check("R1", "byte mask in reset", 64'(dqm), 64'hF);
        check("R1", "clock enable in reset", 64'(cke), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", 64'(req_ready), 64'd1);
        check("R1", "command after reset", 64'({cs_n, ras_n, cas_n, we_n}), 64'(NOP));

        // single request from idle (R2, R3), fields scrambled after acceptance (R8)
        send(2'd0, 12'h123, 8'h45,
             128'h44444444_33333333_22222222_11111111, "R2");
        go_idle();
        repeat (GAP + 4) @(negedge clk);

        // requests held valid back to back, fields changing while busy (R10, R8)
        send(2'd1, 12'h0A5, 8'h00,
             128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98, "R2");
        send(2'd2, 12'h5A0, 8'h7F,
             128'h00000000_FFFFFFFF_00000000_FFFFFFFF, "R10");
        send(2'd3, 12'hFFF, 8'hFF,
             128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C, "R10");
        go_idle();

        // request raised in the middle of the recovery window (R7)
        repeat (6) @(negedge clk);
        send(2'd1, 12'h800, 8'h01,
             128'h0F0F0F0F_F0F0F0F0_12345678_9ABCDEF0, "R7");
        go_idle();

        // request raised long after the window closed
        repeat (GAP + 6) @(negedge clk);
        send(2'd2, 12'h001, 8'h80,
             128'h11112222_33334444_55556666_77778888, "R2");
        go_idle();

        repeat (GAP + 6) @(negedge clk);
        check("R5", "expected activity left over", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule